// File: doc/BRIEF.md
# Memory-mapped SPI flash read engine

This block turns word reads on a memory-mapped bus window into complete SPI flash read sequences. One packed setup word describes the read: which opcode is sent, how many address bytes follow it, how many idle clocks the flash needs before it returns data, and whether data comes back on one, two or four lines. Opcode and address always go out on a single line (io0). Only the data phase widens to two or four lines.

Each accepted request selects a chip, sends the opcode, the address and the dummy clocks, collects 32 data bits, releases the chip, and then pulses a one-cycle ready flag together with the word. A mode switch decides who owns the SPI pins. When the switch is on, this engine drives them. When it is off, a separate command engine's pins pass straight through, and any bus read returns at once with zero data and an error flag.

Top module: `mmspi_read_engine`

## Requirements
- R1: The setup word is decoded as follows: bits 7:0 are the read opcode, bits 9:8 the address byte count (0 to 3), bits 11:10 the dummy byte count, bits 13:12 the data line mode and bits 28:24 an extra dummy bit count. Bits 23:16 (write opcode) and all other bits have no effect on a read.
- R2: SPI clock mode 0 is used: sclk idles low, io0 changes while sclk is low, and every bit is sampled on the rising edge. Each sclk phase lasts one system clock. The opcode goes out MSB first on io0, followed by the low N bytes of the request address MSB first (N = address byte count; N = 0 sends no address).
- R3: Between the address and the data the engine issues 8 x (dummy bytes) + (dummy bits) sclk cycles, and captures nothing during them.
- R4: The data phase is 32 bits. Mode 0 uses 32 clocks on io1. Mode 1 uses 16 clocks on {io1,io0}. Mode 3 uses 8 clocks on {io3,io2,io1,io0}. Mode 2 behaves like mode 0. The first bits received become the MSBs of rsp_data.
- R5: A chip-select field value k in 1..NUM_CS drives spi_cs_n[k-1] low for the whole sequence and leaves every other chip select high. In memory-mapped mode at most one chip select is ever low.
- R6: When a request is accepted at clock edge E0, rsp_ready is high for exactly one cycle, following edge E0+2N+2, where N is the total number of sclk cycles. All chip selects are already high in that cycle.
- R7: With the switch off (cfg_mm_on = 0), spi_sclk, spi_cs_n and io0 follow cmd_sclk, cmd_cs_n and cmd_mosi, io0 alone is enabled, and cmd_miso follows io1. A bus read in this mode gets rsp_ready with rsp_err = 1 and rsp_data = 0 in the cycle after acceptance, and no chip select is asserted.
- R8: A chip-select field of 0, or one above NUM_CS, completes in the same way as R7 (error, zero data, one cycle, no chip select).
- R9: A request made while a read is in progress is ignored: it produces no extra response and does not alter the read in flight.
- R10: The setup word and the address are captured when the request is accepted. Changing cfg_setup during a read does not affect that read.
- R11: In memory-mapped mode io0 is output-enabled only during the opcode and address clocks. io1 to io3 are never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_setup | input | 32 | Packed read setup word (R1) |
| cfg_mm_on | input | 1 | Pin ownership switch: 1 memory-mapped engine, 0 command engine |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Read byte address |
| req_cs | input | CS_FIELD_W | Chip-select field, index plus one, 0 = none |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was rejected (valid with rsp_ready) |
| rsp_data | output | 32 | Read word (valid with rsp_ready) |
| cmd_sclk | input | 1 | Command engine serial clock |
| cmd_cs_n | input | NUM_CS | Command engine chip selects |
| cmd_mosi | input | 1 | Command engine serial output |
| cmd_miso | output | 1 | Serial input returned to the command engine |
| spi_sclk | output | 1 | SPI serial clock pin |
| spi_cs_n | output | NUM_CS | SPI chip-select pins, active low |
| spi_io_out | output | 4 | SPI data line outputs io3..io0 |
| spi_io_oe | output | 4 | SPI data line output enables |
| spi_io_in | input | 4 | SPI data line inputs io3..io0 |

## Verification
A behavioural flash model on the pins decodes the opcode and address the engine sends and returns a data stream derived from the address. Single, dual, quad and the reserved mode are run against the same address function, so a wrong lane order or bit packing shows up as a different word. The header variants cover three, two, one and zero address bytes, dummy bytes and dummy bits, and the exact latency count catches any extra or missing clock. The rejection paths (switch off, chip-select field zero or out of range), the command pass-through, and a second request plus a setup change during a read check that none of these disturbs the pins or the word in flight.

// File: rtl/mmspi_pkg.sv
// Package: shared types and helpers of the memory-mapped SPI read engine.
// Assumes the setup word layout given in the brief (R1).
package mmspi_pkg;

    localparam int CNT_W = 7;   // holds the longest phase (55 dummy clocks)

    typedef enum logic [1:0] {
        LN_SINGLE = 2'd0,
        LN_DUAL   = 2'd1,
        LN_RSVD   = 2'd2,
        LN_QUAD   = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] addr_bytes;
        logic [1:0] dummy_bytes;
        lane_mode_e mode;
        logic [4:0] dummy_bits;
    } rd_setup_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSON,
        ST_HDR,
        ST_DUMMY,
        ST_DATA,
        ST_CSOFF,
        ST_RESP
    } seq_state_e;

    // Pick out the fields a read uses from the packed setup word.
    function automatic rd_setup_t unpack_setup(input logic [31:0] w);
        rd_setup_t s;
        s.opcode      = w[7:0];
        s.addr_bytes  = w[9:8];
        s.dummy_bytes = w[11:10];
        s.mode        = lane_mode_e'(w[13:12]);
        s.dummy_bits  = w[28:24];
        return s;
    endfunction

    // Left-justify the low n address bytes in a 24-bit field.
    function automatic logic [23:0] place_addr(input logic [23:0] a, input logic [1:0] n);
        logic [23:0] r;
        case (n)
            2'd0:    r = 24'h0;
            2'd1:    r = {a[7:0], 16'h0};
            2'd2:    r = {a[15:0], 8'h0};
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mmspi_req_front.sv
// Module: request front end. Accepts a bus read only when the sequencer is
// idle, checks the switch and the chip-select field, and snapshots the
// setup word, address and chip index for the sequencer.
// Assumes req_cs carries index plus one, with 0 meaning no device.
module mmspi_req_front
    import mmspi_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int ADDR_W     = 24,
    parameter int CS_FIELD_W = 3,
    localparam int CS_IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid_i,
    input  logic [ADDR_W-1:0]     req_addr_i,
    input  logic [CS_FIELD_W-1:0] req_cs_i,
    input  logic                  mm_on_i,
    input  logic [31:0]           setup_word_i,
    input  logic                  idle_i,
    output logic                  go_o,
    output logic                  rej_o,
    output rd_setup_t             setup_o,
    output logic [23:0]           addr_o,
    output logic [CS_IDX_W-1:0]   cs_idx_o
);

    localparam logic [CS_FIELD_W-1:0] CS_MAX = CS_FIELD_W'(NUM_CS);

    logic                  accept;
    logic                  cs_ok;
    logic [CS_FIELD_W-1:0] cs_m1;
    logic [23:0]           addr24;
    logic                  unused_setup_bits;

    // Reduce the request address to the 24 bits a flash header can carry.
    generate
        if (ADDR_W >= 24) begin : g_wide_addr
            assign addr24 = req_addr_i[23:0];
        end else begin : g_narrow_addr
            assign addr24 = {{(24 - ADDR_W){1'b0}}, req_addr_i};
        end
    endgenerate

    // Setup bits that a read never looks at (write opcode, spares).
    assign unused_setup_bits = ^{setup_word_i[31:29], setup_word_i[23:14]};

    assign accept = req_valid_i && idle_i;
    assign cs_ok  = (req_cs_i != '0) && (req_cs_i <= CS_MAX);
    assign cs_m1  = req_cs_i - CS_FIELD_W'(1);
    assign go_o   = accept && mm_on_i && cs_ok;
    assign rej_o  = accept && !(mm_on_i && cs_ok);

    // Snapshot the request and its setup when a read is started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_o  <= '0;
            addr_o   <= '0;
            cs_idx_o <= '0;
        end else if (go_o) begin
            setup_o  <= unpack_setup(setup_word_i);
            addr_o   <= addr24;
            cs_idx_o <= cs_m1[CS_IDX_W-1:0];
        end
    end

endmodule

// File: rtl/mmspi_seq.sv
// Module: read sequencer. Walks chip-select setup, opcode/address header,
// dummy clocks and the data phase, generating SPI mode-0 clocks with one
// system clock per sclk phase, then releases the chip and pulses ready.
// Assumes setup_i and addr_i stay stable from go_i until ready_o.
module mmspi_seq
    import mmspi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic        rej_i,
    input  rd_setup_t   setup_i,
    input  logic [23:0] addr_i,
    input  logic [3:0]  io_in_i,
    output logic        idle_o,
    output logic        sclk_o,
    output logic        cs_act_o,
    output logic        mosi_o,
    output logic        io0_oe_o,
    output logic        ready_o,
    output logic        err_o,
    output logic [31:0] data_o
);

    seq_state_e       state_q;
    logic             ph_q;
    logic             sclk_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      hdr_q;
    logic [31:0]      rx_q;
    logic [31:0]      rx_next;
    logic [CNT_W-1:0] hdr_len;
    logic [CNT_W-1:0] dmy_len;
    logic [CNT_W-1:0] dat_len;
    logic             last_clk;

    // Phase lengths in sclk cycles, taken from the captured setup.
    assign hdr_len = CNT_W'(8) + CNT_W'({setup_i.addr_bytes, 3'b000});
    assign dmy_len = CNT_W'({setup_i.dummy_bytes, 3'b000}) + CNT_W'(setup_i.dummy_bits);

    // Data clocks and the next capture value for the selected line mode.
    always_comb begin
        case (setup_i.mode)
            LN_QUAD: begin
                dat_len = CNT_W'(8);
                rx_next = {rx_q[27:0], io_in_i};
            end
            LN_DUAL: begin
                dat_len = CNT_W'(16);
                rx_next = {rx_q[29:0], io_in_i[1:0]};
            end
            default: begin
                dat_len = CNT_W'(32);
                rx_next = {rx_q[30:0], io_in_i[1]};
            end
        endcase
    end

    assign last_clk = (cnt_q == '0);

    // Advance the sequence one sclk phase or one control step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
            sclk_q  <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
            hdr_q   <= '0;
            rx_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (rej_i) begin
                        err_q   <= 1'b1;
                        state_q <= ST_RESP;
                    end else if (go_i) begin
                        err_q   <= 1'b0;
                        rx_q    <= '0;
                        state_q <= ST_CSON;
                    end
                end
                ST_CSON: begin
                    hdr_q   <= {setup_i.opcode, place_addr(addr_i, setup_i.addr_bytes)};
                    cnt_q   <= hdr_len - CNT_W'(1);
                    ph_q    <= 1'b0;
                    state_q <= ST_HDR;
                end
                ST_HDR, ST_DUMMY, ST_DATA: begin
                    if (!ph_q) begin
                        ph_q   <= 1'b1;
                        sclk_q <= 1'b1;
                        if (state_q == ST_DATA) begin
                            rx_q <= rx_next;
                        end
                    end else begin
                        ph_q   <= 1'b0;
                        sclk_q <= 1'b0;
                        if (state_q == ST_HDR) begin
                            hdr_q <= {hdr_q[30:0], 1'b0};
                        end
                        if (!last_clk) begin
                            cnt_q <= cnt_q - CNT_W'(1);
                        end else if (state_q == ST_HDR) begin
                            if (dmy_len != '0) begin
                                cnt_q   <= dmy_len - CNT_W'(1);
                                state_q <= ST_DUMMY;
                            end else begin
                                cnt_q   <= dat_len - CNT_W'(1);
                                state_q <= ST_DATA;
                            end
                        end else if (state_q == ST_DUMMY) begin
                            cnt_q   <= dat_len - CNT_W'(1);
                            state_q <= ST_DATA;
                        end else begin
                            state_q <= ST_CSOFF;
                        end
                    end
                end
                ST_CSOFF: state_q <= ST_RESP;
                ST_RESP:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle_o   = (state_q == ST_IDLE);
    assign sclk_o   = sclk_q;
    assign cs_act_o = (state_q == ST_CSON) || (state_q == ST_HDR) ||
                      (state_q == ST_DUMMY) || (state_q == ST_DATA);
    assign mosi_o   = (state_q == ST_HDR) && hdr_q[31];
    assign io0_oe_o = (state_q == ST_HDR);
    assign ready_o  = (state_q == ST_RESP);
    assign err_o    = ready_o && err_q;
    assign data_o   = (ready_o && !err_q) ? rx_q : 32'h0;

endmodule

// File: rtl/mmspi_pin_mux.sv
// Module: SPI pin owner switch. Decodes the engine's chip index into
// per-chip selects and hands sclk, chip selects and io lines either to the
// memory-mapped engine or to the command engine.
// Assumes the command engine uses io0 out and io1 in only.
module mmspi_pin_mux #(
    parameter int NUM_CS    = 4,
    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                mm_on_i,
    input  logic                eng_sclk_i,
    input  logic                eng_cs_act_i,
    input  logic [CS_IDX_W-1:0] eng_cs_idx_i,
    input  logic                eng_mosi_i,
    input  logic                eng_io0_oe_i,
    input  logic                cmd_sclk_i,
    input  logic [NUM_CS-1:0]   cmd_cs_n_i,
    input  logic                cmd_mosi_i,
    output logic                cmd_miso_o,
    output logic                spi_sclk_o,
    output logic [NUM_CS-1:0]   spi_cs_n_o,
    output logic [3:0]          spi_io_out_o,
    output logic [3:0]          spi_io_oe_o,
    input  logic [3:0]          spi_io_in_i
);

    logic [NUM_CS-1:0] eng_cs_n;

    // One decoded select per chip.
    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
            assign eng_cs_n[i] = !(eng_cs_act_i && (eng_cs_idx_i == CS_IDX_W'(i)));
        end
    endgenerate

    // Route pins to the current owner.
    always_comb begin
        if (mm_on_i) begin
            spi_sclk_o   = eng_sclk_i;
            spi_cs_n_o   = eng_cs_n;
            spi_io_out_o = {3'b000, eng_mosi_i};
            spi_io_oe_o  = {3'b000, eng_io0_oe_i};
        end else begin
            spi_sclk_o   = cmd_sclk_i;
            spi_cs_n_o   = cmd_cs_n_i;
            spi_io_out_o = {3'b000, cmd_mosi_i};
            spi_io_oe_o  = 4'b0001;
        end
    end

    assign cmd_miso_o = spi_io_in_i[1];

endmodule

// File: rtl/mmspi_read_engine.sv
// Module: top of the memory-mapped SPI flash read engine. Connects the
// request front, the read sequencer and the pin owner switch.
// Assumes one outstanding read at a time; a request is taken only when idle.
module mmspi_read_engine #(
    parameter int NUM_CS     = 4,
    parameter int ADDR_W     = 24,
    parameter int CS_FIELD_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           cfg_setup,
    input  logic                  cfg_mm_on,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [CS_FIELD_W-1:0] req_cs,
    output logic                  rsp_ready,
    output logic                  rsp_err,
    output logic [31:0]           rsp_data,
    input  logic                  cmd_sclk,
    input  logic [NUM_CS-1:0]     cmd_cs_n,
    input  logic                  cmd_mosi,
    output logic                  cmd_miso,
    output logic                  spi_sclk,
    output logic [NUM_CS-1:0]     spi_cs_n,
    output logic [3:0]            spi_io_out,
    output logic [3:0]            spi_io_oe,
    input  logic [3:0]            spi_io_in
);

    import mmspi_pkg::*;

    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic                go;
    logic                rej;
    logic                idle;
    rd_setup_t           lat_setup;
    logic [23:0]         lat_addr;
    logic [CS_IDX_W-1:0] lat_cs_idx;
    logic                eng_sclk;
    logic                eng_cs_act;
    logic                eng_mosi;
    logic                eng_io0_oe;

    mmspi_req_front #(
        .NUM_CS     (NUM_CS),
        .ADDR_W     (ADDR_W),
        .CS_FIELD_W (CS_FIELD_W)
    ) front_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_addr_i   (req_addr),
        .req_cs_i     (req_cs),
        .mm_on_i      (cfg_mm_on),
        .setup_word_i (cfg_setup),
        .idle_i       (idle),
        .go_o         (go),
        .rej_o        (rej),
        .setup_o      (lat_setup),
        .addr_o       (lat_addr),
        .cs_idx_o     (lat_cs_idx)
    );

    mmspi_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .rej_i    (rej),
        .setup_i  (lat_setup),
        .addr_i   (lat_addr),
        .io_in_i  (spi_io_in),
        .idle_o   (idle),
        .sclk_o   (eng_sclk),
        .cs_act_o (eng_cs_act),
        .mosi_o   (eng_mosi),
        .io0_oe_o (eng_io0_oe),
        .ready_o  (rsp_ready),
        .err_o    (rsp_err),
        .data_o   (rsp_data)
    );

    mmspi_pin_mux #(
        .NUM_CS (NUM_CS)
    ) mux_i (
        .mm_on_i      (cfg_mm_on),
        .eng_sclk_i   (eng_sclk),
        .eng_cs_act_i (eng_cs_act),
        .eng_cs_idx_i (lat_cs_idx),
        .eng_mosi_i   (eng_mosi),
        .eng_io0_oe_i (eng_io0_oe),
        .cmd_sclk_i   (cmd_sclk),
        .cmd_cs_n_i   (cmd_cs_n),
        .cmd_mosi_i   (cmd_mosi),
        .cmd_miso_o   (cmd_miso),
        .spi_sclk_o   (spi_sclk),
        .spi_cs_n_o   (spi_cs_n),
        .spi_io_out_o (spi_io_out),
        .spi_io_oe_o  (spi_io_oe),
        .spi_io_in_i  (spi_io_in)
    );

endmodule

// File: rtl/mmspi_read_engine_chk.sv
// Module: protocol checker for the read engine, bound to its top.
// Assumes a synchronous active-low reset.
module mmspi_read_engine_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mm_on,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic              rsp_ready,
    input logic              rsp_err,
    input logic [31:0]       rsp_data
);

    AST_SINGLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        mm_on |-> $onehot0(~spi_cs_n));                              // R5

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);                                   // R6

    AST_CS_RELEASED_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_on && rsp_ready) |-> (&spi_cs_n));                       // R6

    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && rsp_err) |-> (rsp_data == 32'h0));             // R7

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_on && (&spi_cs_n)) |-> !spi_sclk);                       // R2

endmodule

bind mmspi_read_engine mmspi_read_engine_chk #(
    .NUM_CS (NUM_CS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mm_on     (cfg_mm_on),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data)
);

// File: tb/mmspi_read_engine_tb_top.sv
// Bench: directed scenarios with a behavioural flash model on the pins.
module mmspi_read_engine_tb_top;

    localparam int NUM_CS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       cfg_setup = 32'h0;
    logic              cfg_mm_on = 1'b1;
    logic              req_valid = 1'b0;
    logic [23:0]       req_addr = 24'h0;
    logic [2:0]        req_cs = 3'd0;
    logic              rsp_ready, rsp_err;
    logic [31:0]       rsp_data;
    logic              cmd_sclk = 1'b0;
    logic [NUM_CS-1:0] cmd_cs_n = '1;
    logic              cmd_mosi = 1'b0;
    logic              cmd_miso;
    logic              spi_sclk;
    logic [NUM_CS-1:0] spi_cs_n;
    logic [3:0]        spi_io_out, spi_io_oe, spi_io_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10ns clk = ~clk;

    mmspi_read_engine #(.NUM_CS(NUM_CS), .ADDR_W(24), .CS_FIELD_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_mm_on(cfg_mm_on),
        .req_valid(req_valid), .req_addr(req_addr), .req_cs(req_cs),
        .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n), .cmd_mosi(cmd_mosi), .cmd_miso(cmd_miso),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
        .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
    );

    // ---------------- flash model ----------------
    int                fl_cnt = 0;
    int                m_ab = 3, m_hdr = 32, m_lanes = 1;
    logic [7:0]        fl_op = 8'h0;
    logic [23:0]       fl_addr = 24'h0;
    logic [3:0]        fl_io = 4'h0;
    logic              fl_oe_bad = 1'b0;
    logic [NUM_CS-1:0] fl_cs_seen = '1;

    assign spi_io_in = fl_io;

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[3:0], a[23:20]} ^ 8'h5C;
    endfunction

    function automatic logic [31:0] fword(input logic [23:0] a);
        return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
    endfunction

    function automatic logic [23:0] mask_addr(input logic [23:0] a, input int n);
        case (n)
            0:       return 24'h0;
            1:       return {16'h0, a[7:0]};
            2:       return {8'h0, a[15:0]};
            default: return a;
        endcase
    endfunction

    always @(posedge spi_sclk) begin
        if (!(&spi_cs_n)) begin
            fl_cs_seen = spi_cs_n;
            if (fl_cnt < 8) fl_op = {fl_op[6:0], spi_io_out[0]};
            else if (fl_cnt < 8 + 8 * m_ab) fl_addr = {fl_addr[22:0], spi_io_out[0]};
            if (fl_cnt < 8 + 8 * m_ab) begin
                if (spi_io_oe !== 4'b0001) fl_oe_bad = 1'b1;
            end else if (spi_io_oe !== 4'b0000) fl_oe_bad = 1'b1;
            fl_cnt++;
        end
    end

    always @(negedge spi_sclk) begin
        logic [31:0] w;
        int p;
        if (!(&spi_cs_n) && fl_cnt >= m_hdr) begin
            w = fword(fl_addr);
            p = (fl_cnt - m_hdr) * m_lanes;
            fl_io = 4'h0;
            for (int j = 0; j < m_lanes; j++) begin
                if (p + j < 32) begin
                    if (m_lanes == 1) fl_io[1] = w[31 - p - j];
                    else fl_io[m_lanes - 1 - j] = w[31 - p - j];
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Reset and check the idle outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rsp_ready == 1'b0, "R6 ready low in reset", {31'h0, rsp_ready}, 32'h0);
        chk(&spi_cs_n, "R5 selects high in reset", {28'h0, spi_cs_n}, 32'hF);
        chk(spi_sclk == 1'b0, "R2 sclk idle low", {31'h0, spi_sclk}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One memory-mapped read, checked on the pins and at the response.
    task automatic t_read(input logic [31:0] setup, input logic [23:0] addr, input logic [2:0] cs,
                          input bit busy_poke, input string dtag);
        int ab, db, dbits, mode, lanes, n, exp_cyc, cyc;
        logic [23:0] fa;
        logic [31:0] exp;
        ab = int'(setup[9:8]); db = int'(setup[11:10]); dbits = int'(setup[28:24]);
        mode = int'(setup[13:12]);
        lanes = (mode == 3) ? 4 : (mode == 1) ? 2 : 1;
        m_ab = ab; m_hdr = 8 + 8 * ab + 8 * db + dbits; m_lanes = lanes;
        fl_cnt = 0; fl_addr = 24'h0; fl_op = 8'h0; fl_oe_bad = 1'b0; fl_io = 4'h0; fl_cs_seen = '1;
        fa = mask_addr(addr, ab);
        exp = fword(fa);
        n = m_hdr + 32 / lanes;
        exp_cyc = 2 * n + 3;
        cfg_setup = setup;
        req_valid = 1'b1; req_addr = addr; req_cs = cs;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) req_valid = 1'b0;
            if (busy_poke && cyc == 20) begin
                req_valid = 1'b1; req_addr = ~addr; req_cs = 3'd1 + 3'(cs % 3'd4);
                cfg_setup = 32'h1F00_3FA5;          // R10: changed setup mid-read
            end
            if (busy_poke && cyc == 21) req_valid = 1'b0;
        end while (!rsp_ready && cyc < 3000);
        chk(cyc == exp_cyc, "R6 latency", cyc, exp_cyc);
        chk(rsp_data == exp, dtag, rsp_data, exp);
        chk(rsp_err == 1'b0, "R4 no error", {31'h0, rsp_err}, 32'h0);
        chk(fl_op == setup[7:0], "R2 opcode", {24'h0, fl_op}, {24'h0, setup[7:0]});
        chk(fl_addr == fa, "R2 address", {8'h0, fl_addr}, {8'h0, fa});
        chk(fl_cs_seen == ~(NUM_CS'(1) << (cs - 3'd1)), "R5 chip select",
            {28'h0, fl_cs_seen}, {28'h0, ~(NUM_CS'(1) << (cs - 3'd1))});
        chk(&spi_cs_n, "R6 selects released at ready", {28'h0, spi_cs_n}, 32'hF);
        chk(fl_oe_bad == 1'b0, "R11 output enables", {31'h0, fl_oe_bad}, 32'h0);
        @(negedge clk);
        chk(rsp_ready == 1'b0, "R6 single-cycle ready", {31'h0, rsp_ready}, 32'h0);
        if (busy_poke) begin
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                chk(rsp_ready == 1'b0 && (&spi_cs_n), "R9 busy request ignored",
                    {27'h0, spi_cs_n, rsp_ready}, 32'h1E);
            end
        end
        cfg_setup = setup;
    endtask

    // A read that must be refused at once with zero data.
    task automatic t_reject(input logic mm, input logic [2:0] cs, input string tag);
        cfg_mm_on = mm;
        req_valid = 1'b1; req_addr = 24'h123456; req_cs = cs;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_ready == 1'b1, tag, {31'h0, rsp_ready}, 32'h1);
        chk(rsp_err == 1'b1, tag, {31'h0, rsp_err}, 32'h1);
        chk(rsp_data == 32'h0, tag, rsp_data, 32'h0);
        chk(&spi_cs_n, tag, {28'h0, spi_cs_n}, 32'hF);
        @(negedge clk);
        chk(rsp_ready == 1'b0 && (&spi_cs_n), tag, {27'h0, spi_cs_n, rsp_ready}, 32'h1E);
        cfg_mm_on = 1'b1;
        @(negedge clk);
    endtask

    // Pins follow the command engine when the switch is off.
    task automatic t_cmd_pass();
        cfg_mm_on = 1'b0;
        cmd_sclk = 1'b1; cmd_cs_n = 4'b0101; cmd_mosi = 1'b1; fl_io = 4'b0010;
        @(negedge clk);
        chk(spi_sclk == 1'b1, "R7 sclk pass-through", {31'h0, spi_sclk}, 32'h1);
        chk(spi_cs_n == 4'b0101, "R7 select pass-through", {28'h0, spi_cs_n}, 32'h5);
        chk(spi_io_out == 4'b0001 && spi_io_oe == 4'b0001, "R7 io0 pass-through",
            {24'h0, spi_io_out, spi_io_oe}, 32'h11);
        chk(cmd_miso == 1'b1, "R7 miso from io1", {31'h0, cmd_miso}, 32'h1);
        fl_io = 4'b1101;
        cmd_mosi = 1'b0;
        @(negedge clk);
        chk(cmd_miso == 1'b0 && spi_io_out == 4'b0000, "R7 miso/mosi follow",
            {27'h0, spi_io_out, cmd_miso}, 32'h0);
        cmd_cs_n = 4'b1111;
        @(negedge clk);
        cmd_sclk = 1'b0;
        fl_io = 4'h0;
        @(negedge clk);
        cfg_mm_on = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #3ms;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        summary();
    end

    initial begin
        t_reset();
        t_read(32'h0012_0303, 24'hA1B2C3, 3'd1, 1'b0, "R4 single data");
        t_read(32'h0012_176B, 24'h00F0E7, 3'd2, 1'b0, "R4 dual data");
        t_read(32'h0012_376C, 24'h3C5A96, 3'd4, 1'b0, "R4 quad data");
        t_read(32'h05FF_060B, 24'h7E1234, 3'd3, 1'b0, "R3 dummy bytes and bits, R1 write field ignored");
        t_read(32'h0000_213B, 24'hFFEE81, 3'd1, 1'b0, "R4 reserved mode as single");
        t_read(32'h0000_309F, 24'h445566, 3'd2, 1'b0, "R2 no address bytes");
        t_read(32'h0012_0303, 24'h0ACE01, 3'd3, 1'b1, "R10 setup change ignored");
        t_reject(1'b0, 3'd1, "R7 switch off rejects");
        t_reject(1'b1, 3'd0, "R8 select field zero rejects");
        t_reject(1'b1, 3'd5, "R8 select field out of range rejects");
        t_cmd_pass();
        t_read(32'h0012_176B, 24'h010203, 3'd4, 1'b0, "R4 dual data after rejects");
        summary();
    end

endmodule